// File: doc/BRIEF.md
# Circular Floating-Point Register Stack

This block holds eight floating-point registers for an arithmetic unit and gives them a stack view. A wrapping top pointer decides which physical register is the stack top. Each physical register carries a tag that marks it as valid or empty. Two combinational read ports and one write port take indices relative to the top, so that index i means physical register (top + i) mod 8.

An arithmetic operation names two source indices, a destination index and an optional pop. The unit outside the block computes the result from the two read ports in the same cycle, and the block commits that result at the clock edge. A push places a value one slot below the current top and makes that slot the new top.

Faults are reported with a one-cycle flag. Reading an empty register gives a stack underflow, and pushing onto an occupied register gives a stack overflow. A condition bit records which of the two faults happened last.

Top module: `fp_reg_stack`

## Requirements
- R1: After reset `top_o` is 0, all eight tags are empty (`valid_o` = 0), `cond_o` is 0 and both fault flags are 0.
- R2: `rd_a_data` and `rd_b_data` show physical register (`top_o` + index) mod 8 for their index, with no delay.
- R3: A push with no operation in the same cycle, aimed at an empty slot, sets `top_o` to (`top_o` − 1) mod 8, writes `push_data` to that slot and marks it valid. A push from top 0 wraps to 7.
- R4: A push whose target slot is already valid is an overflow. The next cycle shows `overflow_o` = 1 and `cond_o` = 1, and the registers, the tags and `top_o` are unchanged.
- R5: An operation whose two sources are valid writes `op_result` to physical register (`top_o` + `op_dst_idx`) mod 8 and marks it valid.
- R6: An operation with `op_pop` = 1 computes its write slot from the old top. In the same edge it clears the tag of the old top and sets `top_o` to (`top_o` + 1) mod 8. A pop from top 7 wraps to 0.
- R7: The combining form (sources 0 and 1, destination 1, pop) leaves its result as the new index-0 register.
- R8: Both sources may name the same register (index 0 with index 0). This is not an underflow.
- R9: An operation with an empty source register is an underflow. Nothing is written, tags and `top_o` are unchanged, and the next cycle shows `underflow_o` = 1 and `cond_o` = 0.
- R10: When `op_valid` and `push_valid` are both high, the operation is carried out and the push is ignored.
- R11: An operation with destination 0 and a pop leaves the old top register empty: the pop wins over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 3 | Relative index, read port A |
| rd_b_idx | input | 3 | Relative index, read port B |
| rd_a_data | output | W | Contents at relative index A |
| rd_b_data | output | W | Contents at relative index B |
| op_valid | input | 1 | Commit an operation result this cycle |
| op_dst_idx | input | 3 | Relative index of the destination |
| op_pop | input | 1 | Pop after the write |
| op_result | input | W | Result value to store |
| push_valid | input | 1 | Push request |
| push_data | input | W | Value to push |
| top_o | output | 3 | Current top pointer |
| valid_o | output | 8 | Tags per physical register, 1 = valid |
| cond_o | output | 1 | Condition bit: 0 after underflow, 1 after overflow |
| underflow_o | output | 1 | Underflow in the previous cycle |
| overflow_o | output | 1 | Overflow in the previous cycle |

## Verification
Two kinds of work can meet at one clock edge. The first is a result write paired with a pop, where the write slot must come from the old top while the tag clear and the pointer step also act on that old top. This is provoked with destination 1 (the combining form), with destination 2, and with destination 0, where the pop must win. Each case is judged by reading indices 0 and 1 and the tag vector on the following cycle. The second is an operation and a push raised together. The bench judges it by checking that the top pointer did not move, that no overflow was flagged, and that index 0 holds the operation's result.

// File: rtl/fp_reg_stack.sv
module fp_reg_stack #(
  parameter int W = 80,
  parameter int D = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [$clog2(D)-1:0] rd_a_idx,
  input  logic [$clog2(D)-1:0] rd_b_idx,
  output logic [W-1:0]         rd_a_data,
  output logic [W-1:0]         rd_b_data,
  input  logic                 op_valid,
  input  logic [$clog2(D)-1:0] op_dst_idx,
  input  logic                 op_pop,
  input  logic [W-1:0]         op_result,
  input  logic                 push_valid,
  input  logic [W-1:0]         push_data,
  output logic [$clog2(D)-1:0] top_o,
  output logic [D-1:0]         valid_o,
  output logic                 cond_o,
  output logic                 underflow_o,
  output logic                 overflow_o
);
  localparam int AW = $clog2(D);
  localparam logic [AW-1:0] ONE = 1;

  logic [W-1:0]  regs [D];
  logic [AW-1:0] top;
  logic [D-1:0]  vld;

  wire [AW-1:0] pa   = top + rd_a_idx;
  wire [AW-1:0] pb   = top + rd_b_idx;
  wire [AW-1:0] pw   = top + op_dst_idx;
  wire [AW-1:0] slot = top - ONE;

  wire src_ok  = vld[pa] & vld[pb];
  wire op_do   = op_valid & src_ok;
  wire op_uf   = op_valid & ~src_ok;
  wire push_ok = push_valid & ~op_valid;
  wire push_do = push_ok & ~vld[slot];
  wire push_of = push_ok & vld[slot];

  assign rd_a_data = regs[pa];
  assign rd_b_data = regs[pb];
  assign top_o     = top;
  assign valid_o   = vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top         <= '0;
      vld         <= '0;
      cond_o      <= 1'b0;
      underflow_o <= 1'b0;
      overflow_o  <= 1'b0;
      for (int i = 0; i < D; i++) regs[i] <= '0;
    end else begin
      underflow_o <= op_uf;
      overflow_o  <= push_of;
      if (op_uf)        cond_o <= 1'b0;
      else if (push_of) cond_o <= 1'b1;
      if (op_do) begin
        regs[pw] <= op_result;
        vld[pw]  <= 1'b1;
        if (op_pop) begin
          vld[top] <= 1'b0;
          top      <= top + ONE;
        end
      end else if (push_do) begin
        regs[slot] <= push_data;
        vld[slot]  <= 1'b1;
        top        <= slot;
      end
    end
  end
endmodule

// File: rtl/fp_reg_stack_chk.sv
module fp_reg_stack_chk #(
  parameter int W = 80,
  parameter int D = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [$clog2(D)-1:0] rd_a_idx,
  input logic [$clog2(D)-1:0] rd_b_idx,
  input logic                 op_valid,
  input logic                 op_pop,
  input logic                 push_valid,
  input logic [$clog2(D)-1:0] top_o,
  input logic [D-1:0]         valid_o,
  input logic                 cond_o,
  input logic                 underflow_o,
  input logic                 overflow_o
);
  localparam int AW = $clog2(D);
  localparam logic [AW-1:0] ONE = 1;

  wire [AW-1:0] ia = top_o + rd_a_idx;
  wire [AW-1:0] ib = top_o + rd_b_idx;
  wire [AW-1:0] ip = top_o - ONE;

  a_r9_underflow_clears_cond: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> !cond_o);
  a_r4_overflow_sets_cond: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> cond_o);
  a_r9_underflow_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> ($stable(top_o) && $stable(valid_o)));
  a_r4_overflow_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> ($stable(top_o) && $stable(valid_o)));
  a_r3_push_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !op_valid && !valid_o[ip]) |=> (top_o == $past(top_o) - ONE) && !overflow_o);
  a_r6_pop_steps_up: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_pop && valid_o[ia] && valid_o[ib]) |=>
      (top_o == $past(top_o) + ONE) && !valid_o[$past(top_o)] && !underflow_o);
  a_r10_one_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !(underflow_o && overflow_o));
endmodule

bind fp_reg_stack fp_reg_stack_chk #(.W(W), .D(D)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
  .op_valid(op_valid), .op_pop(op_pop), .push_valid(push_valid),
  .top_o(top_o), .valid_o(valid_o), .cond_o(cond_o),
  .underflow_o(underflow_o), .overflow_o(overflow_o)
);

// File: tb/sim_fp_reg_stack.sv
module sim_fp_reg_stack;
  localparam int W = 80;

  logic clk = 0, rst_n = 0;
  logic [2:0] rd_a_idx = 0, rd_b_idx = 1, op_dst_idx = 0, top_o;
  logic [W-1:0] rd_a_data, rd_b_data, op_result = 0, push_data = 0;
  logic op_valid = 0, op_pop = 0, push_valid = 0;
  logic [7:0] valid_o;
  logic cond_o, underflow_o, overflow_o;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  fp_reg_stack #(.W(W), .D(8)) u0 (.*);

  typedef struct packed {
    logic       is_op;
    logic [2:0] a, b, w;
    logic       pop;
    logic [15:0] d;
    logic [2:0] etop;
    logic       euf, eof, econd;
    logic [15:0] e0, e1;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{1'b0, 3'd0, 3'd0, 3'd0, 1'b0, 16'd10,  3'd7, 1'b0, 1'b0, 1'b0, 16'd10,  16'd0},   // R3 wrap 0->7
    '{1'b0, 3'd0, 3'd0, 3'd0, 1'b0, 16'd20,  3'd6, 1'b0, 1'b0, 1'b0, 16'd20,  16'd10},  // R3
    '{1'b0, 3'd0, 3'd0, 3'd0, 1'b0, 16'd30,  3'd5, 1'b0, 1'b0, 1'b0, 16'd30,  16'd20},  // R3
    '{1'b1, 3'd0, 3'd1, 3'd1, 1'b0, 16'd50,  3'd5, 1'b0, 1'b0, 1'b0, 16'd30,  16'd50},  // R5 write ST(1)
    '{1'b1, 3'd0, 3'd0, 3'd0, 1'b0, 16'd60,  3'd5, 1'b0, 1'b0, 1'b0, 16'd60,  16'd50},  // R8 same source
    '{1'b1, 3'd0, 3'd1, 3'd1, 1'b1, 16'd110, 3'd6, 1'b0, 1'b0, 1'b0, 16'd110, 16'd10},  // R7 combine+pop
    '{1'b1, 3'd0, 3'd3, 3'd0, 1'b0, 16'd99,  3'd6, 1'b1, 1'b0, 1'b0, 16'd110, 16'd10},  // R9 empty source
    '{1'b1, 3'd0, 3'd1, 3'd2, 1'b1, 16'd77,  3'd7, 1'b0, 1'b0, 1'b0, 16'd10,  16'd77}   // R6 wrap, old-top slot
  };

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit is_op, input bit psh, input logic [2:0] a, input logic [2:0] b,
                      input logic [2:0] w, input bit pop, input logic [W-1:0] od, input logic [W-1:0] pd);
    @(negedge clk);
    op_valid = is_op; push_valid = psh; rd_a_idx = a; rd_b_idx = b;
    op_dst_idx = w; op_pop = pop; op_result = od; push_data = pd;
    @(negedge clk);
    op_valid = 0; push_valid = 0; rd_a_idx = 0; rd_b_idx = 1; op_pop = 0;
    #1;
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    chk(top_o == 0, "R1 top", W'(top_o), 0);
    chk(valid_o == 0, "R1 tags", W'(valid_o), 0);
    chk(!cond_o && !underflow_o && !overflow_o, "R1 flags", W'({cond_o, underflow_o, overflow_o}), 0);

    for (int i = 0; i < 8; i++) begin
      string tag;
      tag = TBL[i].euf ? "R9" : (!TBL[i].is_op ? "R3" : (TBL[i].pop ? "R6" : "R5"));
      step(TBL[i].is_op, !TBL[i].is_op, TBL[i].a, TBL[i].b, TBL[i].w, TBL[i].pop,
           W'(TBL[i].d), W'(TBL[i].d));
      chk(top_o == TBL[i].etop, tag, W'(top_o), W'(TBL[i].etop));
      chk(underflow_o == TBL[i].euf && overflow_o == TBL[i].eof && cond_o == TBL[i].econd,
          tag, W'({underflow_o, overflow_o, cond_o}), W'({TBL[i].euf, TBL[i].eof, TBL[i].econd}));
      chk(rd_a_data == W'(TBL[i].e0), "R2 index 0", rd_a_data, W'(TBL[i].e0));
      chk(rd_b_data == W'(TBL[i].e1), "R2 index 1", rd_b_data, W'(TBL[i].e1));
    end
    chk(valid_o == 8'h81, "R6 old top cleared", W'(valid_o), 8'h81);

    for (int v = 1; v <= 6; v++) step(0, 1, 0, 1, 0, 0, 0, W'(v));
    chk(valid_o == 8'hFF && top_o == 1, "R3 fill", W'({top_o, valid_o}), W'({3'd1, 8'hFF}));
    step(0, 1, 0, 1, 0, 0, 0, 200);
    chk(overflow_o && cond_o && !underflow_o, "R4 flags", W'({overflow_o, cond_o, underflow_o}), 3'b110);
    chk(top_o == 1 && rd_a_data == 6, "R4 state kept", rd_a_data, 6);

    step(1, 1, 0, 1, 0, 0, 99, 55);
    chk(top_o == 1 && !overflow_o, "R10 push ignored", W'({top_o, overflow_o}), W'({3'd1, 1'b0}));
    chk(rd_a_data == 99, "R10 op done", rd_a_data, 99);

    step(1, 0, 0, 1, 0, 1, 42, 0);
    chk(top_o == 2 && valid_o == 8'hFD, "R11 pop wins", W'({top_o, valid_o}), W'({3'd2, 8'hFD}));

    step(1, 0, 7, 0, 0, 0, 5, 0);
    chk(underflow_o && !cond_o && top_o == 2 && valid_o == 8'hFD, "R9 after overflow",
        W'({underflow_o, cond_o, top_o, valid_o}), W'({1'b1, 1'b0, 3'd2, 8'hFD}));

    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1; #1;
    chk(top_o == 0 && valid_o == 0 && !cond_o, "R1 re-reset", W'({top_o, valid_o, cond_o}), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule